// File: doc/BRIEF.md
# Manager Bus Transaction Sequencer

This block is the master side of an 8-bit register bus to a controller device. The bus has a data/command select, a read/write select, an active-low strobe and a shared byte lane. Register addresses are never sent on the bus. The slave starts at register 0 and moves up by one with every data access. A transaction is requested with one start pulse, which carries these values:

- an optional status pre-poll;
- a number of bytes to load into the slave's data registers (write data, or address bytes ahead of a read);
- the instruction byte;
- a number of data registers to read back once the instruction has been acknowledged.

The sequencer runs the accesses back to back. After the instruction write it polls the status register until bit 7 reads high. There is no bound on that wait, because a busy slave can take many microseconds to acknowledge. Read results go into a small buffer that the host reads through a synchronous port.

Each access has a strobe-low phase of `LOW_CLKS` clocks followed by a strobe-high phase of `HIGH_CLKS` clocks. Both must be at least 2. The selects and the write byte change only when a strobe falls, so they stay steady through the rising edge that latches a write. They also stay steady for the whole high phase that follows it.

Top module: `mgr_bus_seq`

## Requirements
- R1: During and right after a synchronous reset, the outputs are: strobe high, byte lane not driven, read/write select high, data/command select low, `busy` low, `done` low.
- R2: Every access holds the strobe low for exactly `LOW_CLKS` clocks and then high for exactly `HIGH_CLKS` clocks. The next access of the same transaction begins on the following clock. The selects and the driven byte change only in the clock in which a strobe falls.
- R3: After each rising strobe edge, both selects stay unchanged for at least two clocks.
- R4: The byte lane is driven (`mb_oe` high) for the whole of every write access and at no other time.
- R5: When `prepoll` is set, status reads (data/command low, read/write high) come first and repeat until a read returns bit 7 high. Only then does any other access follow.
- R6: `n_load` write accesses with data/command high carry `load_bytes` byte i, which is bits [8i+7:8i], in access i, in ascending i.
- R7: The instruction is written with both selects low, after the load accesses.
- R8: After the instruction, status reads repeat without limit until bit 7 reads high.
- R9: After acknowledge, `n_read` read accesses with data/command high follow. The byte returned in the last strobe-low clock of access i is stored at buffer index i. That byte appears on `rd_data` one clock after `rd_addr` = i.
- R10: An `n_load` or `n_read` value above `MAX_REGS` is treated as `MAX_REGS`.
- R11: `start` is taken only while `busy` is low. All inputs of a taken request are captured, so later changes and starts while `busy` is high have no effect.
- R12: In the clock right after the final high phase, `done` is high for one clock and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Transaction request, taken while idle |
| prepoll | input | 1 | Poll status for bit 7 before the transaction |
| n_load | input | 4 | Number of data registers to load |
| n_read | input | 4 | Number of data registers to read after acknowledge |
| instr | input | 8 | Instruction byte for the command register |
| load_bytes | input | 104 | Load bytes, byte i in bits [8i+7:8i] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| rd_addr | input | 4 | Read buffer index |
| rd_data | output | 8 | Read buffer byte, one clock after `rd_addr` |
| mb_dc | output | 1 | Data (high) or command/status (low) select |
| mb_rw | output | 1 | Read (high) or write (low) select |
| mb_strb | output | 1 | Strobe, active low |
| mb_dout | output | 8 | Byte driven onto the lane |
| mb_oe | output | 1 | Lane drive enable |
| mb_din | input | 8 | Byte read from the lane |

## Verification
The bench builds the sequencer with `LOW_CLKS` = 3 and `HIGH_CLKS` = 2. Because the two phases differ in length, a swapped or miscounted phase shows up on the first access. `MAX_REGS` stays at 13. With that value a full 13-register load, a full 13-register read and requests of 14 and 15 are all reachable, so the clamp is exercised at the register limit. A model slave in the bench withholds acknowledge for a scripted number of polls, both before and after the instruction, so repeated polling is compared cycle by cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LOAD,
    ST_CMD,
    ST_POLL,
    ST_READ
  } step_t;
endpackage

// File: rtl/mbs_timer.sv
module mbs_timer #(
  parameter int LOW_CLKS  = 2,
  parameter int HIGH_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic strb,
  output logic sample,
  output logic last
);
  localparam int TOT = LOW_CLKS + HIGH_CLKS;
  localparam int CW  = $clog2(TOT + 1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      strb   <= 1'b1;
    end else if (go) begin
      active <= 1'b1;
      cnt    <= '0;
      strb   <= 1'b0;
    end else if (active) begin
      if (cnt == CW'(TOT - 1)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
        if (cnt == CW'(LOW_CLKS - 1)) strb <= 1'b1;
      end
    end
  end

  assign sample = active && (cnt == CW'(LOW_CLKS - 1));
  assign last   = active && (cnt == CW'(TOT - 1));

  // R2
  low_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(strb) |=> !strb);
  // R3
  high_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strb) |=> strb);
  // R2
  go_slot_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> (!active || last));
endmodule

// File: rtl/mbs_rdbuf.sv
module mbs_rdbuf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 13,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MAX_REGS = 13,
  parameter int CNT_W    = $clog2(MAX_REGS + 1),
  parameter int IDX_W    = $clog2(MAX_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       prepoll,
  input  logic [CNT_W-1:0]           n_load,
  input  logic [CNT_W-1:0]           n_read,
  input  logic [DATA_W-1:0]          instr,
  input  logic [MAX_REGS*DATA_W-1:0] load_bytes,
  input  logic [DATA_W-1:0]          bus_din,
  input  logic                       sample,
  input  logic                       last,
  output logic                       go,
  output logic                       dc,
  output logic                       rw,
  output logic                       oe,
  output logic [DATA_W-1:0]          dout,
  output logic                       busy,
  output logic                       done,
  output logic                       buf_we,
  output logic [IDX_W-1:0]           buf_waddr,
  output logic [DATA_W-1:0]          buf_wdata
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_REGS);

  step_t                       step, nxt_step;
  logic [IDX_W-1:0]            idx, nxt_idx;
  logic [CNT_W-1:0]            nl, nr, nl_in, nr_in;
  logic [DATA_W-1:0]           instr_q, cur_instr;
  logic [MAX_REGS*DATA_W-1:0]  bytes_q, cur_bytes;
  logic                        ack_q, issue, finish;
  logic                        more_load, more_read;
  logic                        acc_dc, acc_rw, acc_oe;
  logic [DATA_W-1:0]           acc_dout;

  assign nl_in     = (n_load > CAP) ? CAP : n_load;
  assign nr_in     = (n_read > CAP) ? CAP : n_read;
  assign cur_instr = (step == ST_IDLE) ? instr : instr_q;
  assign cur_bytes = (step == ST_IDLE) ? load_bytes : bytes_q;
  assign more_load = (CNT_W'(idx) + CNT_W'(1)) < nl;
  assign more_read = (CNT_W'(idx) + CNT_W'(1)) < nr;

  always_comb begin
    nxt_step = step;
    nxt_idx  = idx;
    issue    = 1'b0;
    finish   = 1'b0;
    unique case (step)
      ST_IDLE: if (start) begin
        issue    = 1'b1;
        nxt_idx  = '0;
        nxt_step = prepoll ? ST_PRE : ((nl_in != '0) ? ST_LOAD : ST_CMD);
      end
      ST_PRE: if (last) begin
        issue = 1'b1;
        if (ack_q) begin
          nxt_idx  = '0;
          nxt_step = (nl != '0) ? ST_LOAD : ST_CMD;
        end
      end
      ST_LOAD: if (last) begin
        issue = 1'b1;
        if (more_load) nxt_idx = idx + IDX_W'(1);
        else begin
          nxt_idx  = '0;
          nxt_step = ST_CMD;
        end
      end
      ST_CMD: if (last) begin
        issue    = 1'b1;
        nxt_step = ST_POLL;
      end
      ST_POLL: if (last) begin
        if (!ack_q) issue = 1'b1;
        else if (nr != '0) begin
          issue    = 1'b1;
          nxt_idx  = '0;
          nxt_step = ST_READ;
        end else finish = 1'b1;
      end
      ST_READ: if (last) begin
        if (more_read) begin
          issue   = 1'b1;
          nxt_idx = idx + IDX_W'(1);
        end else finish = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    acc_dc   = 1'b0;
    acc_rw   = 1'b1;
    acc_oe   = 1'b0;
    acc_dout = '0;
    unique case (nxt_step)
      ST_LOAD: begin
        acc_dc   = 1'b1;
        acc_rw   = 1'b0;
        acc_oe   = 1'b1;
        acc_dout = cur_bytes[nxt_idx*DATA_W +: DATA_W];
      end
      ST_CMD: begin
        acc_rw   = 1'b0;
        acc_oe   = 1'b1;
        acc_dout = cur_instr;
      end
      ST_READ: acc_dc = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step  <= ST_IDLE;
      idx   <= '0;
      nl    <= '0;
      nr    <= '0;
      dc    <= 1'b0;
      rw    <= 1'b1;
      oe    <= 1'b0;
      dout  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sample) ack_q <= bus_din[DATA_W-1];
      if (step == ST_IDLE && start) begin
        nl      <= nl_in;
        nr      <= nr_in;
        instr_q <= instr;
        bytes_q <= load_bytes;
      end
      if (issue) begin
        step  <= nxt_step;
        idx   <= nxt_idx;
        dc    <= acc_dc;
        rw    <= acc_rw;
        oe    <= acc_oe;
        busy  <= 1'b1;
        ack_q <= 1'b0;
        if (acc_oe) dout <= acc_dout;
      end else if (finish) begin
        step <= ST_IDLE;
        busy <= 1'b0;
        done <= 1'b1;
        oe   <= 1'b0;
      end
    end
  end

  assign go        = issue;
  assign buf_we    = sample && (step == ST_READ);
  assign buf_waddr = idx;
  assign buf_wdata = bus_din;

  // R4
  oe_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    oe |-> !rw);
  // R8
  poll_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (last && step == ST_CMD) |=> (rw && !dc && busy));
  // R11
  start_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/mgr_bus_seq.sv
module mgr_bus_seq #(
  parameter int DATA_W    = 8,
  parameter int MAX_REGS  = 13,
  parameter int LOW_CLKS  = 2,
  parameter int HIGH_CLKS = 2,
  parameter int CNT_W     = $clog2(MAX_REGS + 1),
  parameter int IDX_W     = $clog2(MAX_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       prepoll,
  input  logic [CNT_W-1:0]           n_load,
  input  logic [CNT_W-1:0]           n_read,
  input  logic [DATA_W-1:0]          instr,
  input  logic [MAX_REGS*DATA_W-1:0] load_bytes,
  output logic                       busy,
  output logic                       done,
  input  logic [IDX_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       mb_dc,
  output logic                       mb_rw,
  output logic                       mb_strb,
  output logic [DATA_W-1:0]          mb_dout,
  output logic                       mb_oe,
  input  logic [DATA_W-1:0]          mb_din
);
  logic              go, sample, last, buf_we;
  logic [IDX_W-1:0]  buf_waddr;
  logic [DATA_W-1:0] buf_wdata;

  mbs_timer #(.LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS)) u_timer (
    .clk(clk), .rst(rst), .go(go), .strb(mb_strb), .sample(sample), .last(last)
  );

  mbs_ctrl #(.DATA_W(DATA_W), .MAX_REGS(MAX_REGS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .prepoll(prepoll),
    .n_load(n_load), .n_read(n_read), .instr(instr), .load_bytes(load_bytes),
    .bus_din(mb_din), .sample(sample), .last(last), .go(go),
    .dc(mb_dc), .rw(mb_rw), .oe(mb_oe), .dout(mb_dout),
    .busy(busy), .done(done),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
  );

  mbs_rdbuf #(.DATA_W(DATA_W), .DEPTH(MAX_REGS), .AW(IDX_W)) u_rdbuf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mb_strb) |=> ($stable(mb_rw) && $stable(mb_dc)));
  // R2
  low_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!mb_strb && !$past(mb_strb)) |->
      ($stable(mb_dc) && $stable(mb_rw) && $stable(mb_dout) && $stable(mb_oe)));
endmodule

// File: tb/test_mgr_bus_seq.sv
module test_mgr_bus_seq;
  localparam int DW = 8, MR = 13, LC = 3, HC = 2, CW = 4, IW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, start = 1'b0, prepoll = 1'b0;
  logic [CW-1:0] n_load = '0, n_read = '0;
  logic [DW-1:0] instr = '0;
  logic [MR*DW-1:0] load_bytes = '0;
  logic [IW-1:0] rd_addr = '0;
  logic busy, done, mb_dc, mb_rw, mb_strb, mb_oe;
  logic [DW-1:0] rd_data, mb_dout, mb_din;

  mgr_bus_seq #(.DATA_W(DW), .MAX_REGS(MR), .LOW_CLKS(LC), .HIGH_CLKS(HC)) i_mgr_bus_seq (
    .clk(clk), .rst(rst), .start(start), .prepoll(prepoll),
    .n_load(n_load), .n_read(n_read), .instr(instr), .load_bytes(load_bytes),
    .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data),
    .mb_dc(mb_dc), .mb_rw(mb_rw), .mb_strb(mb_strb), .mb_dout(mb_dout),
    .mb_oe(mb_oe), .mb_din(mb_din)
  );

  int checks = 0, failures = 0, cyc = 0;
  logic [13:0] exp_q[$];
  int tag_q[$];
  logic last_dc = 1'b0, last_rw = 1'b1, m_dc = 1'b0, m_rw = 1'b1;
  bit run_cmp = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] rbank(input int i);
    return 8'h3C ^ 8'(i * 11);
  endfunction

  // model slave
  logic [7:0] wreg [MR];
  logic [7:0] instr_log = '0;
  int ptr = 0, sreads = 0, nwr = 0, nrd = 0, pre_n = 0, post_n = 0;
  bit instr_done = 1'b0;
  logic prev_strb = 1'b1, prev_busy = 1'b0, ack;

  always_comb begin
    ack = instr_done ? (sreads >= post_n) : (sreads >= pre_n);
    if (!mb_strb && mb_rw) mb_din = mb_dc ? rbank(ptr) : {ack, 7'h15};
    else mb_din = 8'hFF;
  end

  always @(negedge clk) begin
    if (busy && !prev_busy) begin
      ptr = 0; sreads = 0; nwr = 0; nrd = 0; instr_done = 1'b0;
    end
    if (!prev_strb && mb_strb) begin
      if (!mb_rw) begin
        if (mb_dc) begin
          if (ptr < MR) wreg[ptr] = mb_dout;
          ptr++; nwr++;
        end else begin
          instr_log = mb_dout; instr_done = 1'b1; ptr = 0; sreads = 0;
        end
      end else if (mb_dc) begin
        ptr++; nrd++;
      end else sreads++;
    end
    prev_strb = mb_strb;
    prev_busy = busy;
  end

  // per-cycle reference comparison
  always @(negedge clk) begin
    logic [13:0] e, a;
    int t;
    if (run_cmp) begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = {1'b1, last_dc, last_rw, 3'b000, 8'h00};
        t = 2; // R2 idle between transactions
      end
      last_dc = e[12];
      last_rw = e[11];
      a = {mb_strb, mb_dc, mb_rw, mb_oe, busy, done, mb_oe ? mb_dout : 8'h00};
      chk(a === e, $sformatf("R%0d", t), "bus cycle", int'(a), int'(e));
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // R2 R3 R4: LC strobe-low cycles then HC high cycles, fields held throughout
  task automatic push_acc(input logic dc, input logic rw, input logic oe,
                          input logic [7:0] d, input int tag);
    for (int k = 0; k < LC + HC; k++) begin
      exp_q.push_back({(k >= LC), dc, rw, oe, 1'b1, 1'b0, oe ? d : 8'h00});
      tag_q.push_back(tag);
    end
    m_dc = dc;
    m_rw = rw;
  endtask

  task automatic run_txn(input bit pre, input int pn, input int nl, input int nr,
                         input int qn, input logic [7:0] ins, input int seed,
                         input bit junk);
    int nlc, nrc;
    logic [MR*DW-1:0] b;
    nlc = (nl > MR) ? MR : nl;
    nrc = (nr > MR) ? MR : nr;
    for (int i = 0; i < MR; i++) b[i*8 +: 8] = 8'(seed + i * 37);
    @(negedge clk); #1;
    pre_n = pn; post_n = qn;
    prepoll = pre; n_load = CW'(nl); n_read = CW'(nr); instr = ins;
    load_bytes = b; start = 1'b1;
    if (pre) for (int i = 0; i <= pn; i++) push_acc(1'b0, 1'b1, 1'b0, 8'h00, 5); // R5
    for (int i = 0; i < nlc; i++) push_acc(1'b1, 1'b0, 1'b1, b[i*8 +: 8], 6);   // R6
    push_acc(1'b0, 1'b0, 1'b1, ins, 7);                                        // R7
    for (int i = 0; i <= qn; i++) push_acc(1'b0, 1'b1, 1'b0, 8'h00, 8);        // R8
    for (int i = 0; i < nrc; i++) push_acc(1'b1, 1'b1, 1'b0, 8'h00, 9);        // R9
    exp_q.push_back({1'b1, m_dc, m_rw, 3'b001, 8'h00});                        // R12
    tag_q.push_back(12);
    @(negedge clk); #1;
    start = 1'b0;
    if (junk) begin
      // R11: start and changed inputs while busy must be ignored
      prepoll = ~pre; n_load = 4'd1; n_read = 4'd2; instr = 8'hEE;
      load_bytes = ~b; start = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(nwr == nlc, (nl > MR) ? "R10" : "R6", "load count", nwr, nlc);
    for (int i = 0; i < nlc; i++)
      chk(wreg[i] === b[i*8 +: 8], "R6", "loaded byte", int'(wreg[i]), int'(b[i*8 +: 8]));
    chk(instr_log === ins, "R7", "instruction", int'(instr_log), int'(ins));
    chk(nrd == nrc, (nr > MR) ? "R10" : "R9", "read count", nrd, nrc);
    for (int i = 0; i < nrc; i++) begin
      #1 rd_addr = IW'(i);
      @(negedge clk);
      chk(rd_data === rbank(i), "R9", "buffer byte", int'(rd_data), int'(rbank(i)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mb_strb, mb_oe, mb_rw, mb_dc, busy, done} === 6'b101000, "R1", "reset outputs",
        int'({mb_strb, mb_oe, mb_rw, mb_dc, busy, done}), 6'b101000);
    #1 rst = 1'b0;
    run_cmp = 1'b1;
    run_txn(1'b0, 0, 3, 0, 2, 8'h05, 8'h10, 1'b1);   // write, busy start ignored (R11)
    run_txn(1'b1, 3, 13, 0, 0, 8'h01, 8'h40, 1'b0);  // prepoll held off 3 reads (R5)
    run_txn(1'b0, 0, 2, 5, 1, 8'h02, 8'h77, 1'b0);   // address load then read
    run_txn(1'b1, 0, 0, 13, 4, 8'h06, 8'h00, 1'b0);  // full read, long poll (R8)
    run_txn(1'b0, 0, 0, 0, 0, 8'h0A, 8'h00, 1'b0);   // instruction only
    run_txn(1'b1, 1, 15, 14, 0, 8'h09, 8'h99, 1'b0); // counts above limit (R10)
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule